// File: doc/BRIEF.md
# Dual-Channel Storage Controller Register File

This block is the host-visible register file of a two-channel serial storage host controller. It sits behind a 512-byte memory window and answers single-cycle byte and word accesses. Each channel has a command byte, a six-bit scratch byte, a DMA status byte, a configuration word carrying the latched device interrupt, a link control word, a link status word and an interrupt-enable field. Two summary words gather the command, interrupt and DMA status of both channels so that one read can serve an interrupt handler.

The block samples each channel's device interrupt level into a flag and drives one host interrupt line that is the OR of both flags. A write to a channel's link control word with bit 0 set gives that channel a one-cycle reset pulse. Accesses to the task-file windows and to the DMA address words are not stored here. They are passed to external logic through a request strobe that carries the channel, the window kind and the local offset. The read data for those accesses is returned in the same cycle. The read map and the write map are deliberately different: several offsets accept writes but read as zero.

Top module: `dual_chan_regblock`

## Requirements
- R1: After reset every stored register reads zero, `host_irq` and `chan_rst` are low, and the configuration words read 0x6515_0000.
- R2: A read of any offset that has no read function returns zero (this includes 0x03, 0x0B, 0x11, 0x12, 0x19 and 0x1A). A write to any offset that has no write function changes no register.
- R3: Channel c (c = 0, 1) has its command byte at 8c+0, its scratch byte at 8c+1 and its DMA status byte at 8c+2. They read back in bits 7:0, and a scratch write keeps only bits 5:0.
- R4: Writes at 0x10/0x11/0x12 act as writes to channel 0's command, scratch and status bytes, and writes at 0x18/0x19/0x1A act as writes to channel 1's.
- R5: In a DMA status byte, bit 2 (interrupt) and bit 1 (error) are cleared by writing 1 and kept by writing 0. The other bits take the written value. A one-cycle pulse on `dma_int_set[c]` sets bit 2, and a set takes priority over a clear in the same cycle.
- R6: A read of 0x10 returns channel 0's command in bits 7:0, with bit 4 ORed with channel 0's interrupt flag and bit 6 ORed with channel 1's. Bit 14 is channel 1's status bit 2. Bits 23:16 hold channel 0's status and bits 31:24 hold channel 1's.
- R7: A read of 0x18 returns channel 1's command in bits 7:0, with bit 4 ORed with channel 1's interrupt flag, and channel 1's status in bits 23:16.
- R8: The configuration words at 0xA0 and 0xE0 read {0x6515, 4'b0, flag, 11'b0}. The flag in bit 11 equals `chan_irq[c]` as sampled at the previous clock edge, and `host_irq` is the OR of the two flags.
- R9: The link control words at 0x100 and 0x180 store bits 11:0 of a write. A write with bit 0 set makes `chan_rst[c]` high for exactly the one cycle that follows the write.
- R10: The link status words at 0x104 and 0x184 read 0x113 while `dev_present[c]` is high and zero otherwise.
- R11: The interrupt-enable words at 0x148 and 0x1C8 store `wdata[31:16] & 0x3EED` and read it back in bits 31:16 with zeros below.
- R12: An access to 0x80-0x87 / 0xC0-0xC7 (`ext_sel`=0, offset addr[2:0]), to 0x8A / 0xCA (`ext_sel`=1, offset 2) or to 8c+4..8c+7 (`ext_sel`=2, offset addr[1:0]) raises `ext_req` with `ext_chan`=c. In that same cycle a read returns `ext_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 9 | Byte offset in the window |
| bus_wdata | input | 32 | Write data (byte registers use bits 7:0) |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| chan_irq | input | 2 | Device interrupt level per channel |
| dev_present | input | 2 | Device attached per channel |
| dma_int_set | input | 2 | Pulse that sets status bit 2 per channel |
| host_irq | output | 1 | Host interrupt line |
| chan_rst | output | 2 | One-cycle reset pulse per channel |
| ext_req | output | 1 | Forwarded access strobe |
| ext_we | output | 1 | Forwarded access is a write |
| ext_chan | output | 1 | Channel of the forwarded access |
| ext_sel | output | 2 | 0 task-file data, 1 task-file control, 2 DMA address |
| ext_off | output | 3 | Local offset in the forwarded window |
| ext_wdata | output | 32 | Forwarded write data |
| ext_rdata | input | 32 | Read data from the external window |

## Verification
The collision that matters is a host write to a DMA status byte that clears bit 2 in the same cycle as the DMA engine's `dma_int_set` pulse for that channel. The bench raises the pulse on the very clock edge that commits the write-one-to-clear. It passes if bit 2 is still set on the next read while the other written bits have taken the new value. A second overlap, an interrupt level change while a summary word is being read, is provoked by random reads between level changes. The result is judged against a model that updates the flag only after the edge.

// File: rtl/dcr_pkg.sv
package dcr_pkg;

   // per-channel address hits produced by the decoder
   typedef struct packed {
      logic cmd_rd;
      logic cmd_wr;
      logic sw_rd;
      logic sw_wr;
      logic st_rd;
      logic st_wr;
      logic dma_addr;
      logic tf_data;
      logic tf_ctl;
      logic conf;
      logic sctl;
      logic sstat;
      logic sien;
   } chan_hit_t;

   localparam logic [7:0] ST_W1C_MASK = 8'h06;
   localparam int         ST_INT_BIT  = 2;

   localparam logic [1:0] SEL_TF_DATA = 2'd0;
   localparam logic [1:0] SEL_TF_CTL  = 2'd1;
   localparam logic [1:0] SEL_DMA_ADR = 2'd2;

endpackage

// File: rtl/dcr_decode.sv
module dcr_decode
   import dcr_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int NUM_CH = 2
) (
   input  logic [ADDR_W-1:0] addr,
   output chan_hit_t         hit [NUM_CH],
   output logic              sum_all,
   output logic              sum_one
);

   generate
      if (ADDR_W < 9) begin : g_bad_addr
         $error("dcr_decode: ADDR_W must cover a 512-byte window");
      end
   endgenerate

   assign sum_all = (addr == ADDR_W'(16));
   assign sum_one = (addr == ADDR_W'(24));

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         localparam int DMA_B   = c * 8;
         localparam int ALIAS_B = 16 + c * 8;
         localparam int TF_B    = 128 + c * 64;
         localparam int LINK_B  = 256 + c * 128;
         chan_hit_t h;
         assign h.cmd_rd   = (addr == ADDR_W'(DMA_B));
         assign h.cmd_wr   = (addr == ADDR_W'(DMA_B)) || (addr == ADDR_W'(ALIAS_B));
         assign h.sw_rd    = (addr == ADDR_W'(DMA_B + 1));
         assign h.sw_wr    = (addr == ADDR_W'(DMA_B + 1)) || (addr == ADDR_W'(ALIAS_B + 1));
         assign h.st_rd    = (addr == ADDR_W'(DMA_B + 2));
         assign h.st_wr    = (addr == ADDR_W'(DMA_B + 2)) || (addr == ADDR_W'(ALIAS_B + 2));
         assign h.dma_addr = ((addr >> 2) == ADDR_W'((DMA_B + 4) >> 2));
         assign h.tf_data  = ((addr >> 3) == ADDR_W'(TF_B >> 3));
         assign h.tf_ctl   = (addr == ADDR_W'(TF_B + 10));
         assign h.conf     = (addr == ADDR_W'(TF_B + 32));
         assign h.sctl     = (addr == ADDR_W'(LINK_B));
         assign h.sstat    = (addr == ADDR_W'(LINK_B + 4));
         assign h.sien     = (addr == ADDR_W'(LINK_B + 72));
         assign hit[c] = h;
      end
   endgenerate

endmodule

// File: rtl/dcr_chan.sv
module dcr_chan
   import dcr_pkg::*;
#(
   parameter int          SW_W      = 6,
   parameter int          SCTL_W    = 12,
   parameter logic [15:0] SIEN_MASK = 16'h3EED
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_cmd,
   input  logic              we_sw,
   input  logic              we_st,
   input  logic              we_sctl,
   input  logic              we_sien,
   input  logic [31:0]       wdata,
   input  logic              irq_in,
   input  logic              int_set,
   output logic [7:0]        cmd,
   output logic [SW_W-1:0]   sw,
   output logic [7:0]        st,
   output logic              irq_flag,
   output logic [SCTL_W-1:0] sctl,
   output logic [15:0]       sien,
   output logic              rst_pulse
);

   generate
      if (SW_W > 8 || SCTL_W > 16) begin : g_bad_width
         $error("dcr_chan: field widths exceed their words");
      end
   endgenerate

   logic [7:0] st_nxt;
   logic       unused_wdata;
   assign unused_wdata = ^wdata;

   always_comb begin
      st_nxt = st;
      if (we_st)
         st_nxt = (wdata[7:0] & ~ST_W1C_MASK) | (st & ST_W1C_MASK & ~wdata[7:0]);
      if (int_set)
         st_nxt[ST_INT_BIT] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd       <= '0;
         sw        <= '0;
         st        <= '0;
         irq_flag  <= 1'b0;
         sctl      <= '0;
         sien      <= '0;
         rst_pulse <= 1'b0;
      end else begin
         irq_flag  <= irq_in;
         st        <= st_nxt;
         rst_pulse <= we_sctl && wdata[0];
         if (we_cmd)  cmd  <= wdata[7:0];
         if (we_sw)   sw   <= wdata[SW_W-1:0];
         if (we_sctl) sctl <= wdata[SCTL_W-1:0];
         if (we_sien) sien <= wdata[31:16] & SIEN_MASK;
      end
   end

   // R8: flag mirrors the level one edge late
   assert_irq_track_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (irq_flag == $past(irq_in)));

   // R9: a pulse only follows a control write that also stored bit 0
   assert_rst_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rst_pulse |-> sctl[0]);

   // R9: control word holds when not written
   assert_sctl_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !$past(we_sctl)) |-> $stable(sctl));

   // R5: a clear without a concurrent set leaves bit 2 low
   assert_w1c_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $past(we_st && wdata[ST_INT_BIT] && !int_set)) |-> !st[ST_INT_BIT]);

endmodule

// File: rtl/dual_chan_regblock.sv
module dual_chan_regblock
   import dcr_pkg::*;
#(
   parameter int          ADDR_W    = 9,
   parameter int          DATA_W    = 32,
   parameter int          NUM_CH    = 2,
   parameter int          SW_W      = 6,
   parameter int          SCTL_W    = 12,
   parameter logic [15:0] CONF_ID   = 16'h6515,
   parameter logic [15:0] SIEN_MASK = 16'h3EED,
   parameter logic [11:0] LINK_UP   = 12'h113,
   localparam int         CH_W      = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_valid,
   input  logic              bus_write,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic [NUM_CH-1:0] chan_irq,
   input  logic [NUM_CH-1:0] dev_present,
   input  logic [NUM_CH-1:0] dma_int_set,
   output logic              host_irq,
   output logic [NUM_CH-1:0] chan_rst,
   output logic              ext_req,
   output logic              ext_we,
   output logic [CH_W-1:0]   ext_chan,
   output logic [1:0]        ext_sel,
   output logic [2:0]        ext_off,
   output logic [DATA_W-1:0] ext_wdata,
   input  logic [DATA_W-1:0] ext_rdata
);

   generate
      if (DATA_W != 32) begin : g_bad_data
         $error("dual_chan_regblock: DATA_W must be 32");
      end
      if (NUM_CH != 2) begin : g_bad_ch
         $error("dual_chan_regblock: the summary map needs exactly two channels");
      end
   endgenerate

   chan_hit_t         hit [NUM_CH];
   logic              sum_all, sum_one;
   logic              wr;
   logic [7:0]        cmd_v  [NUM_CH];
   logic [SW_W-1:0]   sw_v   [NUM_CH];
   logic [7:0]        st_v   [NUM_CH];
   logic [SCTL_W-1:0] sctl_v [NUM_CH];
   logic [15:0]       sien_v [NUM_CH];
   logic [NUM_CH-1:0] irq_v;

   assign wr = bus_valid && bus_write;

   dcr_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_dec (
      .addr    (bus_addr),
      .hit     (hit),
      .sum_all (sum_all),
      .sum_one (sum_one)
   );

   generate
      for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
         dcr_chan #(.SW_W(SW_W), .SCTL_W(SCTL_W), .SIEN_MASK(SIEN_MASK)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .we_cmd    (wr && hit[c].cmd_wr),
            .we_sw     (wr && hit[c].sw_wr),
            .we_st     (wr && hit[c].st_wr),
            .we_sctl   (wr && hit[c].sctl),
            .we_sien   (wr && hit[c].sien),
            .wdata     (bus_wdata),
            .irq_in    (chan_irq[c]),
            .int_set   (dma_int_set[c]),
            .cmd       (cmd_v[c]),
            .sw        (sw_v[c]),
            .st        (st_v[c]),
            .irq_flag  (irq_v[c]),
            .sctl      (sctl_v[c]),
            .sien      (sien_v[c]),
            .rst_pulse (chan_rst[c])
         );
      end
   endgenerate

   assign host_irq = |irq_v;

   // forwarding of task-file and DMA address windows
   always_comb begin
      ext_req  = 1'b0;
      ext_chan = '0;
      ext_sel  = SEL_TF_DATA;
      ext_off  = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (hit[c].tf_data || hit[c].tf_ctl || hit[c].dma_addr) begin
            ext_req  = bus_valid;
            ext_chan = CH_W'(c);
            if (hit[c].dma_addr) begin
               ext_sel = SEL_DMA_ADR;
               ext_off = {1'b0, bus_addr[1:0]};
            end else if (hit[c].tf_ctl) begin
               ext_sel = SEL_TF_CTL;
               ext_off = 3'd2;
            end else begin
               ext_sel = SEL_TF_DATA;
               ext_off = bus_addr[2:0];
            end
         end
      end
   end
   assign ext_we    = bus_write;
   assign ext_wdata = bus_wdata;

   // read multiplexer
   always_comb begin
      bus_rdata = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (hit[c].cmd_rd) bus_rdata = {24'b0, cmd_v[c]};
         if (hit[c].sw_rd)  bus_rdata = {{(DATA_W-SW_W){1'b0}}, sw_v[c]};
         if (hit[c].st_rd)  bus_rdata = {24'b0, st_v[c]};
         if (hit[c].dma_addr || hit[c].tf_data || hit[c].tf_ctl) bus_rdata = ext_rdata;
         if (hit[c].conf)   bus_rdata = {CONF_ID, 4'b0, irq_v[c], 11'b0};
         if (hit[c].sctl)   bus_rdata = {{(DATA_W-SCTL_W){1'b0}}, sctl_v[c]};
         if (hit[c].sstat)  bus_rdata = dev_present[c] ? {20'b0, LINK_UP} : '0;
         if (hit[c].sien)   bus_rdata = {sien_v[c], 16'b0};
      end
      if (sum_all) begin
         bus_rdata        = {st_v[1], st_v[0], 8'b0, cmd_v[0]};
         bus_rdata[4]     = cmd_v[0][4] | irq_v[0];
         bus_rdata[6]     = cmd_v[0][6] | irq_v[1];
         bus_rdata[14]    = st_v[1][ST_INT_BIT];
      end
      if (sum_one) begin
         bus_rdata        = {8'b0, st_v[1], 8'b0, cmd_v[1]};
         bus_rdata[4]     = cmd_v[1][4] | irq_v[1];
      end
   end

   // R8: host line follows the inputs one edge late
   assert_irq_out_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> (host_irq == (|$past(chan_irq))));

endmodule

// File: tb/dual_chan_regblock_tb.sv
module dual_chan_regblock_tb;

   localparam logic [31:0] EXT_PAT = 32'hA5C3_1E07;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_valid = 1'b0;
   logic        bus_write = 1'b0;
   logic [8:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [1:0]  chan_irq = '0;
   logic [1:0]  dev_present = 2'b01;
   logic [1:0]  dma_int_set = '0;
   logic        host_irq;
   logic [1:0]  chan_rst;
   logic        ext_req, ext_we;
   logic [0:0]  ext_chan;
   logic [1:0]  ext_sel;
   logic [2:0]  ext_off;
   logic [31:0] ext_wdata;
   logic [31:0] ext_rdata = EXT_PAT;

   int total = 0;
   int bad = 0;

   // model state
   logic [7:0]  m_cmd [2];
   logic [5:0]  m_sw  [2];
   logic [7:0]  m_st  [2];
   logic [11:0] m_sctl[2];
   logic [15:0] m_sien[2];
   logic [1:0]  m_irq;

   always #10 clk = ~clk;

   dual_chan_regblock u_dut (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .chan_irq(chan_irq), .dev_present(dev_present), .dma_int_set(dma_int_set),
      .host_irq(host_irq), .chan_rst(chan_rst), .ext_req(ext_req), .ext_we(ext_we),
      .ext_chan(ext_chan), .ext_sel(ext_sel), .ext_off(ext_off),
      .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
   );

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] w1c(input logic [7:0] old, input logic [7:0] d);
      return (d & 8'hF9) | (old & 8'h06 & ~d);
   endfunction

   task automatic mwrite(input logic [8:0] a, input logic [31:0] d);
      case (a)
         9'h000, 9'h010: m_cmd[0] = d[7:0];
         9'h001, 9'h011: m_sw[0]  = d[5:0];
         9'h002, 9'h012: m_st[0]  = w1c(m_st[0], d[7:0]);
         9'h008, 9'h018: m_cmd[1] = d[7:0];
         9'h009, 9'h019: m_sw[1]  = d[5:0];
         9'h00A, 9'h01A: m_st[1]  = w1c(m_st[1], d[7:0]);
         9'h100: m_sctl[0] = d[11:0];
         9'h180: m_sctl[1] = d[11:0];
         9'h148: m_sien[0] = d[31:16] & 16'h3EED;
         9'h1C8: m_sien[1] = d[31:16] & 16'h3EED;
         default: ;
      endcase
   endtask

   function automatic logic [31:0] exp_rd(input logic [8:0] a);
      logic [31:0] v;
      v = '0;
      case (a) inside
         9'h000: v = {24'b0, m_cmd[0]};
         9'h001: v = {26'b0, m_sw[0]};
         9'h002: v = {24'b0, m_st[0]};
         9'h008: v = {24'b0, m_cmd[1]};
         9'h009: v = {26'b0, m_sw[1]};
         9'h00A: v = {24'b0, m_st[1]};
         [9'h004:9'h007], [9'h00C:9'h00F], [9'h080:9'h087], 9'h08A,
         [9'h0C0:9'h0C7], 9'h0CA: v = EXT_PAT;
         9'h010: begin
            v = {m_st[1], m_st[0], 8'b0, m_cmd[0]};
            v[4]  = v[4] | m_irq[0];
            v[6]  = v[6] | m_irq[1];
            v[14] = m_st[1][2];
         end
         9'h018: begin
            v = {8'b0, m_st[1], 8'b0, m_cmd[1]};
            v[4] = v[4] | m_irq[1];
         end
         9'h0A0: v = 32'h6515_0000 | (32'(m_irq[0]) << 11);
         9'h0E0: v = 32'h6515_0000 | (32'(m_irq[1]) << 11);
         9'h100: v = {20'b0, m_sctl[0]};
         9'h180: v = {20'b0, m_sctl[1]};
         9'h104: v = dev_present[0] ? 32'h113 : 32'h0;
         9'h184: v = dev_present[1] ? 32'h113 : 32'h0;
         9'h148: v = {m_sien[0], 16'b0};
         9'h1C8: v = {m_sien[1], 16'b0};
         default: v = '0;
      endcase
      return v;
   endfunction

   task automatic wr(input logic [8:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      mwrite(a, d);
   endtask

   task automatic rd(input logic [8:0] a, input string tag);
      logic [31:0] e;
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
      #1;
      e = exp_rd(a);
      chk(bus_rdata == e, $sformatf("%s addr=%h", tag, a), bus_rdata, e);
      bus_valid = 1'b0;
   endtask

   task automatic set_irq(input logic [1:0] v);
      @(negedge clk);
      chan_irq = v;
      @(negedge clk);
      m_irq = v;
      chk(host_irq == (|v), "R8 host_irq", 32'(host_irq), 32'(|v));
   endtask

   function automatic logic [8:0] pick(input int k);
      case (k)
         0: return 9'h000;  1: return 9'h001;  2: return 9'h002;  3: return 9'h003;
         4: return 9'h008;  5: return 9'h009;  6: return 9'h00A;  7: return 9'h010;
         8: return 9'h011;  9: return 9'h012; 10: return 9'h018; 11: return 9'h019;
         12: return 9'h01A; 13: return 9'h0A0; 14: return 9'h0E0; 15: return 9'h100;
         16: return 9'h180; 17: return 9'h104; 18: return 9'h184; 19: return 9'h148;
         20: return 9'h1C8; 21: return 9'h085; 22: return 9'h0CA; 23: return 9'h00D;
         default: return 9'($urandom % 512);
      endcase
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int unsigned seed_set;
      seed_set = $urandom(32'd20251);
      for (int i = 0; i < 2; i++) begin
         m_cmd[i] = '0; m_sw[i] = '0; m_st[i] = '0; m_sctl[i] = '0; m_sien[i] = '0;
      end
      m_irq = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(9'h000, "R1 reset cmd");
      rd(9'h0A0, "R1 reset conf0");
      rd(9'h0E0, "R1 reset conf1");
      rd(9'h148, "R1 reset sien");
      chk(host_irq == 1'b0 && chan_rst == 2'b00, "R1 reset outputs",
          {30'b0, host_irq, chan_rst[0]}, 32'h0);

      // R3 byte registers and scratch width
      wr(9'h000, 32'h0000_00C3); rd(9'h000, "R3 cmd0");
      wr(9'h009, 32'h0000_00FF); rd(9'h009, "R3 sw1 keeps 5:0");
      // R4 aliases
      wr(9'h018, 32'h0000_005A); rd(9'h008, "R4 alias cmd1");
      wr(9'h011, 32'h0000_0015); rd(9'h001, "R4 alias sw0");
      // R2 write-only aliases and holes read zero, unmapped writes ignored
      rd(9'h011, "R2 alias read zero");
      rd(9'h003, "R2 hole read zero");
      wr(9'h1FC, 32'hFFFF_FFFF); rd(9'h1FC, "R2 unmapped");
      rd(9'h000, "R2 cmd0 untouched");

      // R5 W1C and set pulse
      @(negedge clk); dma_int_set = 2'b10;
      @(negedge clk); dma_int_set = 2'b00; m_st[1][2] = 1'b1;
      rd(9'h00A, "R5 set pulse");
      rd(9'h010, "R6 bit14 from ch1 status");
      wr(9'h01A, 32'h0000_00F4); rd(9'h00A, "R5 w1c clears bit2");
      wr(9'h002, 32'h0000_0006); rd(9'h002, "R5 w1c zero keeps");
      // R5 collision: set wins over clear in the same cycle
      @(negedge clk); dma_int_set = 2'b01; m_st[0] = 8'h04;
      @(negedge clk); dma_int_set = 2'b00;
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 9'h002; bus_wdata = 32'h0000_0084;
      dma_int_set = 2'b01;
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0; dma_int_set = 2'b00;
      m_st[0] = w1c(m_st[0], 8'h84); m_st[0][2] = 1'b1;
      rd(9'h002, "R5 set beats clear");

      // R8 interrupt flags, R6/R7 summaries
      set_irq(2'b01); rd(9'h0A0, "R8 conf0 flag"); rd(9'h010, "R6 summary irq0");
      set_irq(2'b10); rd(9'h0E0, "R8 conf1 flag"); rd(9'h018, "R7 summary irq1");
      set_irq(2'b00); rd(9'h010, "R6 summary cleared");

      // R9 control store and reset pulse
      wr(9'h100, 32'hFFFF_F801);
      chk(chan_rst == 2'b01, "R9 pulse ch0", 32'(chan_rst), 32'h1);
      @(negedge clk);
      chk(chan_rst == 2'b00, "R9 pulse one cycle", 32'(chan_rst), 32'h0);
      rd(9'h100, "R9 sctl0 keeps 11:0");
      wr(9'h180, 32'h0000_0AB0);
      chk(chan_rst == 2'b00, "R9 no pulse bit0 clear", 32'(chan_rst), 32'h0);

      // R10 link status
      rd(9'h104, "R10 present"); rd(9'h184, "R10 absent");
      dev_present = 2'b10;
      rd(9'h104, "R10 absent ch0"); rd(9'h184, "R10 present ch1");

      // R11 interrupt enable
      wr(9'h1C8, 32'hFFFF_FFFF); rd(9'h1C8, "R11 sien mask");

      // R12 forwarding
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_addr = 9'h0C6; bus_wdata = 32'h1234_5678;
      #1;
      chk(ext_req && ext_we && ext_chan == 1'b1 && ext_sel == 2'd0 && ext_off == 3'd6 &&
          ext_wdata == 32'h1234_5678, "R12 tf data ch1",
          {ext_req, ext_we, ext_chan, ext_sel, ext_off}, {1'b1, 1'b1, 1'b1, 2'd0, 3'd6});
      bus_addr = 9'h08A; bus_write = 1'b0;
      #1;
      chk(ext_req && ext_chan == 1'b0 && ext_sel == 2'd1 && ext_off == 3'd2 &&
          bus_rdata == EXT_PAT, "R12 tf ctl ch0",
          {ext_req, ext_chan, ext_sel, ext_off}, {1'b1, 1'b0, 2'd1, 3'd2});
      bus_addr = 9'h00E;
      #1;
      chk(ext_req && ext_chan == 1'b1 && ext_sel == 2'd2 && ext_off == 3'd2,
          "R12 dma addr ch1", {ext_req, ext_chan, ext_sel, ext_off}, {1'b1, 1'b1, 2'd2, 3'd2});
      bus_addr = 9'h0A0;
      #1;
      chk(!ext_req, "R12 no strobe off window", 32'(ext_req), 32'h0);
      bus_valid = 1'b0;

      // constrained random mix, R2..R12
      for (int i = 0; i < 600; i++) begin
         logic [8:0] a;
         logic [31:0] d;
         a = pick(int'($urandom % 28));
         d = $urandom;
         if (a == 9'h100 || a == 9'h180) d[0] = 1'b0;
         case ($urandom % 6)
            0, 1, 2: wr(a, d);
            3: set_irq(2'($urandom));
            default: rd(a, "R2-mix random read");
         endcase
         rd(pick(int'($urandom % 28)), "R6 random check");
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule